// File: doc/BRIEF.md
# Processor Status Word with Condition-Code Logic

This block holds the 16-bit status word of a stack-machine processor. It keeps six single-bit mode and flag bits, a 2-bit condition code and an 8-bit code segment number. The condition code is set by a command that names one of three ways to judge its operands: by the sign of a result, by the class of a character byte, or by comparing two operands as signed or unsigned numbers. The condition code uses a fixed, unusual encoding: 0 means greater, 1 means less, 2 means equal, and 3 is illegal.

Software-visible writes reach the word in two ways. A full-word port replaces the whole word. A field port replaces one named field. The condition-code command is a valid/ready stream. The block drops `cc_ready` in any cycle that carries a full-word load, so a command that meets such a load waits and is not lost. `cc_valid` and the operands must stay steady until the cycle in which `cc_valid && cc_ready` holds. The command takes effect at that rising edge. Every write reaches `status` one clock after its edge. The illegal-code flag is a one-cycle pulse that is registered on the same edge.

Top module: `ccsr_status_reg`

## Requirements
- R1: After reset, `status` is 16'h0000, `cc_illegal` is 0, and `cc_ready` is 1 while `wr_word_en` is low.
- R2: Field layout of `status`: [15] privileged, [14] interrupts enabled, [13] traps enabled, [12] right-stack pending, [11] overflow, [10] carry, [9:8] condition code, [7:0] code segment number. Field port selects 0 to 7 address these fields in that order.
- R3: Condition-code encoding is 0 greater, 1 less, 2 equal. In result mode (`cc_mode`=0), `cc_opa` is read as signed: negative gives 1, zero gives 2, positive gives 0.
- R4: In character mode (`cc_mode`=1), only `cc_opa[7:0]` counts. ASCII digits 0x30 to 0x39 give 2. Letters 0x41 to 0x5A and 0x61 to 0x7A give 0. Every other byte gives 1.
- R5: In compare mode (`cc_mode`=2), `cc_opa` is compared against `cc_opb`, signed when `cc_signed`=1 and unsigned otherwise. Less gives 1, equal gives 2, greater gives 0.
- R6: An accepted condition-code command changes only bits [9:8]. An accepted command with `cc_mode`=3 changes nothing.
- R7: A field-port write (`fld_en`) replaces only the selected field, using `fld_val[0]` for a flag, `fld_val[1:0]` for the code and `fld_val[7:0]` for the segment. The field write is ignored in a cycle that carries a full-word load.
- R8: A field write of 3 to the condition code leaves the code unchanged and raises `cc_illegal` for exactly the next cycle. The code never holds 3.
- R9: A full-word load replaces the whole word and wins over every other update in that cycle. If its code field is 3, the old code is kept, the other bits load, and `cc_illegal` pulses.
- R10: `cc_ready` is low in every cycle with `wr_word_en` high. A held command is applied in the first cycle in which it is accepted.
- R11: When an accepted command and a field write fall in the same cycle, the command sets the code. A field write to any other field still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_word_en | input | 1 | Full-word load strobe |
| wr_word | input | 16 | Word to load |
| fld_en | input | 1 | Field write strobe |
| fld_sel | input | 3 | Field select (0 to 7, see R2) |
| fld_val | input | 8 | Field write value |
| cc_valid | input | 1 | Condition-code command valid |
| cc_ready | output | 1 | Command accepted when high with valid |
| cc_mode | input | 2 | 0 result, 1 character, 2 compare, 3 none |
| cc_signed | input | 1 | Signed compare in compare mode |
| cc_opa | input | 16 | Operand 1 / result / character |
| cc_opb | input | 16 | Operand 2 for compare |
| status | output | 16 | Status word |
| cc_illegal | output | 1 | Pulse: a code of 3 was refused |

## Verification
Every field sits in the register that drives `status`, so a wrong internal state shows up at the port one clock after the faulty write. An error in the condition code cannot stay hidden. Each classification vector is chosen so that a wrong class, a wrong signedness or a wrong encoding produces a different 2-bit value at once. A bad merge in the priority logic shows up as a disturbed neighbouring field in the next cycle. A missing or stretched illegal pulse shows up on `cc_illegal` within two cycles.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;

  typedef enum logic [1:0] {
    CC_GT  = 2'd0,
    CC_LT  = 2'd1,
    CC_EQ  = 2'd2,
    CC_BAD = 2'd3
  } cc_e;

  typedef enum logic [1:0] {
    MODE_RESULT = 2'd0,
    MODE_CHAR   = 2'd1,
    MODE_CMP    = 2'd2,
    MODE_NONE   = 2'd3
  } ccmode_e;

  typedef enum logic [2:0] {
    F_PRIV  = 3'd0,
    F_IRQ   = 3'd1,
    F_TRAP  = 3'd2,
    F_RSTK  = 3'd3,
    F_OVF   = 3'd4,
    F_CARRY = 3'd5,
    F_CC    = 3'd6,
    F_SEG   = 3'd7
  } fsel_e;

  localparam int NUM_FLAGS = 6;
  localparam int CC_W      = 2;

  localparam logic [7:0] ASC_0  = 8'h30;
  localparam logic [7:0] ASC_9  = 8'h39;
  localparam logic [7:0] ASC_UA = 8'h41;
  localparam logic [7:0] ASC_UZ = 8'h5A;
  localparam logic [7:0] ASC_LA = 8'h61;
  localparam logic [7:0] ASC_LZ = 8'h7A;

endpackage

// File: rtl/ccsr_classify.sv
module ccsr_classify
  import ccsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        mode,
  input  logic              cmp_signed,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [1:0]        cc,
  output logic              writes
);

  logic [7:0] chr;
  logic       is_digit, is_letter;
  logic       res_neg, res_zero;
  logic       op_lt, op_eq;

  always_comb begin
    chr       = opa[7:0];
    is_digit  = (chr >= ASC_0) && (chr <= ASC_9);
    is_letter = ((chr >= ASC_UA) && (chr <= ASC_UZ)) ||
                ((chr >= ASC_LA) && (chr <= ASC_LZ));
    res_neg   = opa[DATA_W-1];
    res_zero  = (opa == '0);
    op_eq     = (opa == opb);
    if (cmp_signed) op_lt = ($signed(opa) < $signed(opb));
    else            op_lt = (opa < opb);
  end

  always_comb begin
    writes = 1'b1;
    cc     = CC_GT;
    unique case (ccmode_e'(mode))
      MODE_RESULT: cc = res_neg ? CC_LT : (res_zero ? CC_EQ : CC_GT);
      MODE_CHAR:   cc = is_digit ? CC_EQ : (is_letter ? CC_GT : CC_LT);
      MODE_CMP:    cc = op_lt ? CC_LT : (op_eq ? CC_EQ : CC_GT);
      default: begin
        cc     = CC_GT;
        writes = 1'b0;
      end
    endcase
  end

  // R8
  always_comb begin
    if (!$isunknown(cc)) begin
      cls_code_legal_chk: assert (cc != CC_BAD);
    end
  end

endmodule

// File: rtl/ccsr_field_merge.sv
module ccsr_field_merge
  import ccsr_pkg::*;
#(
  parameter int SEG_W = 8,
  localparam int WORD_W = NUM_FLAGS + CC_W + SEG_W
) (
  input  logic [WORD_W-1:0] cur,
  input  logic              en,
  input  logic [2:0]        sel,
  input  logic [SEG_W-1:0]  val,
  output logic [WORD_W-1:0] nxt,
  output logic              bad_cc
);

  localparam int CC_LO = SEG_W;
  localparam int CC_HI = SEG_W + 1;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign nxt[WORD_W-1-i] = (en && (sel == 3'(i))) ? val[0] : cur[WORD_W-1-i];
  end

  assign bad_cc = en && (sel == F_CC) && (val[1:0] == CC_BAD);

  assign nxt[CC_HI:CC_LO] = (en && (sel == F_CC) && !bad_cc) ? val[1:0]
                                                             : cur[CC_HI:CC_LO];

  assign nxt[SEG_W-1:0] = (en && (sel == F_SEG)) ? val : cur[SEG_W-1:0];

endmodule

// File: rtl/ccsr_status_reg.sv
module ccsr_status_reg
  import ccsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 8,
  localparam int WORD_W = NUM_FLAGS + CC_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              fld_en,
  input  logic [2:0]        fld_sel,
  input  logic [SEG_W-1:0]  fld_val,
  input  logic              cc_valid,
  output logic              cc_ready,
  input  logic [1:0]        cc_mode,
  input  logic              cc_signed,
  input  logic [DATA_W-1:0] cc_opa,
  input  logic [DATA_W-1:0] cc_opb,
  output logic [WORD_W-1:0] status,
  output logic              cc_illegal
);

  localparam int CC_LO = SEG_W;
  localparam int CC_HI = SEG_W + 1;

  logic [WORD_W-1:0] status_q, status_d, merged;
  logic              illegal_q, illegal_d;
  logic [1:0]        cls_cc;
  logic              cls_writes, fld_bad, cmd_fire, word_bad;

  ccsr_classify #(.DATA_W(DATA_W)) u_classify (
    .mode       (cc_mode),
    .cmp_signed (cc_signed),
    .opa        (cc_opa),
    .opb        (cc_opb),
    .cc         (cls_cc),
    .writes     (cls_writes)
  );

  ccsr_field_merge #(.SEG_W(SEG_W)) u_merge (
    .cur    (status_q),
    .en     (fld_en),
    .sel    (fld_sel),
    .val    (fld_val),
    .nxt    (merged),
    .bad_cc (fld_bad)
  );

  assign cc_ready = !wr_word_en;
  assign cmd_fire = cc_valid && cc_ready;
  assign word_bad = (wr_word[CC_HI:CC_LO] == CC_BAD);

  always_comb begin
    status_d  = status_q;
    illegal_d = 1'b0;
    if (wr_word_en) begin
      status_d = wr_word;
      if (word_bad) begin
        status_d[CC_HI:CC_LO] = status_q[CC_HI:CC_LO];
        illegal_d = 1'b1;
      end
    end else begin
      status_d  = merged;
      illegal_d = fld_bad;
      if (cmd_fire && cls_writes) status_d[CC_HI:CC_LO] = cls_cc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      status_q  <= status_d;
      illegal_q <= illegal_d;
    end
  end

  assign status     = status_q;
  assign cc_illegal = illegal_q;

  // R9
  word_load_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_en && (wr_word[CC_HI:CC_LO] != CC_BAD)) |=> (status == $past(wr_word)));

  // R6
  cmd_keeps_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_ready && !fld_en) |=>
      ((status[WORD_W-1:CC_HI+1] == $past(status[WORD_W-1:CC_HI+1])) &&
       (status[SEG_W-1:0] == $past(status[SEG_W-1:0]))));

  // R5
  cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_ready && (cc_mode == MODE_CMP) && (cc_opa == cc_opb))
      |=> (status[CC_HI:CC_LO] == CC_EQ));

  // R8
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_illegal |-> $past((wr_word_en && (wr_word[CC_HI:CC_LO] == CC_BAD)) ||
                         (!wr_word_en && fld_en && (fld_sel == F_CC) &&
                          (fld_val[1:0] == CC_BAD))));

  // R8
  code_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[CC_HI:CC_LO] != CC_BAD);

  // R10
  held_cmd_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_en && cc_valid && (wr_word[CC_HI:CC_LO] != CC_BAD))
      |=> (status[CC_HI:CC_LO] == $past(wr_word[CC_HI:CC_LO])));

endmodule

// File: tb/tb_ccsr_status_reg.sv
module tb_ccsr_status_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_word_en;
  logic [15:0] wr_word;
  logic        fld_en;
  logic [2:0]  fld_sel;
  logic [7:0]  fld_val;
  logic        cc_valid;
  logic        cc_ready;
  logic [1:0]  cc_mode;
  logic        cc_signed;
  logic [15:0] cc_opa, cc_opb;
  logic [15:0] status;
  logic        cc_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ccsr_status_reg dut (
    .clk(clk), .rst_n(rst_n),
    .wr_word_en(wr_word_en), .wr_word(wr_word),
    .fld_en(fld_en), .fld_sel(fld_sel), .fld_val(fld_val),
    .cc_valid(cc_valid), .cc_ready(cc_ready), .cc_mode(cc_mode),
    .cc_signed(cc_signed), .cc_opa(cc_opa), .cc_opb(cc_opb),
    .status(status), .cc_illegal(cc_illegal)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic [15:0] a;
    logic [15:0] b;
    logic [1:0]  exp;
  } vec_t;

  // cc: 0 greater, 1 less, 2 equal
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'h8000, 16'h0000, 2'd1},
    '{2'd0, 1'b0, 16'h0000, 16'h0000, 2'd2},
    '{2'd0, 1'b0, 16'h7FFF, 16'h0000, 2'd0},
    '{2'd0, 1'b0, 16'hFFFF, 16'h0000, 2'd1},
    '{2'd1, 1'b0, 16'h0030, 16'h0000, 2'd2},
    '{2'd1, 1'b0, 16'h0041, 16'h0000, 2'd0},
    '{2'd1, 1'b0, 16'h0039, 16'h0000, 2'd2},
    '{2'd1, 1'b0, 16'h003A, 16'h0000, 2'd1},
    '{2'd1, 1'b0, 16'h005A, 16'h0000, 2'd0},
    '{2'd1, 1'b0, 16'h005B, 16'h0000, 2'd1},
    '{2'd1, 1'b0, 16'h0061, 16'h0000, 2'd0},
    '{2'd1, 1'b0, 16'h0040, 16'h0000, 2'd1},
    '{2'd1, 1'b0, 16'h007A, 16'h0000, 2'd0},
    '{2'd1, 1'b0, 16'h1F35, 16'h0000, 2'd2},
    '{2'd2, 1'b1, 16'hFFFF, 16'h0001, 2'd1},
    '{2'd2, 1'b0, 16'hFFFF, 16'h0001, 2'd0},
    '{2'd2, 1'b1, 16'h1234, 16'h1234, 2'd2},
    '{2'd2, 1'b1, 16'h8000, 16'h7FFF, 2'd1},
    '{2'd2, 1'b0, 16'h8000, 16'h7FFF, 2'd0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_word_en = 0; wr_word = '0; fld_en = 0; fld_sel = '0; fld_val = '0;
    cc_valid = 0; cc_mode = 2'd3; cc_signed = 0; cc_opa = '0; cc_opb = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_word(logic [15:0] w);
    idle(); wr_word_en = 1; wr_word = w; step(); idle();
  endtask

  task automatic do_field(logic [2:0] s, logic [7:0] v);
    idle(); fld_en = 1; fld_sel = s; fld_val = v; step(); idle();
  endtask

  task automatic do_cmd(logic [1:0] m, logic sg, logic [15:0] a, logic [15:0] b);
    idle(); cc_valid = 1; cc_mode = m; cc_signed = sg; cc_opa = a; cc_opb = b;
    step(); idle();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", status, 16'h0000);
    check("R1 illegal", {15'd0, cc_illegal}, 16'd0);
    check("R1 ready", {15'd0, cc_ready}, 16'd1);

    // vector walk: each accepted command only changes bits [9:8]
    do_word(16'hA400);
    for (int i = 0; i < NV; i++) begin
      do_cmd(VECS[i].mode, VECS[i].sgn, VECS[i].a, VECS[i].b);
      case (VECS[i].mode)
        2'd0:    check("R3 result mode", status, {6'b101001, VECS[i].exp, 8'h00});
        2'd1:    check("R4 char mode", status, {6'b101001, VECS[i].exp, 8'h00});
        default: check("R5 compare mode", status, {6'b101001, VECS[i].exp, 8'h00});
      endcase
    end

    // R9 full word
    do_word(16'hA5C3);
    check("R9 word load", status, 16'hA5C3);

    // R2 / R7 field layout
    do_word(16'h0000);
    do_field(3'd0, 8'h01); check("R2 priv bit15", status, 16'h8000);
    do_field(3'd5, 8'h01); check("R2 carry bit10", status, 16'h8400);
    do_field(3'd3, 8'h01); check("R2 rstk bit12", status, 16'h9400);
    do_field(3'd7, 8'h3C); check("R7 segment", status, 16'h943C);
    do_field(3'd6, 8'h02); check("R7 cc field", status, 16'h963C);

    // R8 reject code 3
    do_field(3'd6, 8'h03);
    check("R8 code kept", status, 16'h963C);
    check("R8 pulse", {15'd0, cc_illegal}, 16'd1);
    step();
    check("R8 pulse one cycle", {15'd0, cc_illegal}, 16'd0);

    // R6 only cc bits; mode 3 no effect
    do_cmd(2'd0, 1'b0, 16'h8000, 16'h0000);
    check("R6 cmd only cc", status, 16'h953C);
    do_cmd(2'd3, 1'b0, 16'h0000, 16'h0000);
    check("R6 mode none", status, 16'h953C);

    // R10 back-pressure
    idle();
    wr_word_en = 1; wr_word = 16'h0200;
    cc_valid = 1; cc_mode = 2'd0; cc_opa = 16'h0001;
    #1;
    check("R10 ready low", {15'd0, cc_ready}, 16'd0);
    step();
    check("R10 word wins", status, 16'h0200);
    wr_word_en = 0;
    #1;
    check("R10 ready high", {15'd0, cc_ready}, 16'd1);
    step();
    idle();
    check("R10 held cmd applied", status, 16'h0000);

    // R9 word with code 3
    do_word(16'hFF00);
    check("R9 code kept", status, 16'hFC00);
    check("R9 pulse", {15'd0, cc_illegal}, 16'd1);

    // R11 same-cycle merges
    idle();
    fld_en = 1; fld_sel = 3'd0; fld_val = 8'h00;
    cc_valid = 1; cc_mode = 2'd0; cc_opa = 16'h0000;
    step(); idle();
    check("R11 both apply", status, 16'h7E00);
    fld_en = 1; fld_sel = 3'd6; fld_val = 8'h01;
    cc_valid = 1; cc_mode = 2'd1; cc_opa = 16'h0041;
    step(); idle();
    check("R11 cmd wins cc", status, 16'h7C00);

    // R7 field ignored under word load
    idle();
    wr_word_en = 1; wr_word = 16'h0100; fld_en = 1; fld_sel = 3'd7; fld_val = 8'hFF;
    step(); idle();
    check("R7 ignored", status, 16'h0100);
    check("R7 no pulse", {15'd0, cc_illegal}, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule